// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

The controller gathers eight interrupt request lines into a single interrupt output for a processor. Each line is synchronised and edge-detected, and a rising edge latches a pending request. A mask register removes individual lines from arbitration. Among the pending, unmasked lines, the lowest-numbered line wins: line 0 has the highest priority and line 7 the lowest.

An in-service register records which levels the processor is currently handling. A pending request reaches the processor only if it outranks every level in service, so interrupt service routines nest by priority. On a clocked acknowledge the winning level moves from pending to in service, and the controller presents an 8-bit vector. The vector is a programmable base in bits 7:3 with the line number in bits 2:0. The level stays in service until software issues an end-of-interrupt command.

Software uses a small register port made of active-low write and read strobes, one address bit and an 8-bit data bus. Through it software loads the mask, loads the vector base, issues end-of-interrupt commands and reads back the pending requests or the mask.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset `int_o` is 0, the mask is 8'hFF (all lines blocked), no request is pending, no level is in service, the vector base is 0, and `data_o` reads 8'h00 while `rd_ni` is high.
- R2: A rising edge on `irq_i[i]` sets pending bit i by the third rising clock edge after the change. A line held high does not set the bit again.
- R3: Mask bit i at 1 blocks line i from arbitration, and the line's pending bit stays latched while it is masked.
- R4: `int_o` is 1 exactly when some pending, unmasked line exists and the lowest-numbered such line is numbered below every in-service level, or no level is in service. Line 0 has the highest priority.
- R5: While a level is in service, requests at that level or at any higher-numbered (lower-priority) level do not raise `int_o`. A lower-numbered request does raise it.
- R6: If `ack_i` is 1 at a rising clock edge while `int_o` is 1, the winning line's in-service bit is set and its pending bit is cleared. From the next cycle, `data_o` shows {base, line number} while `rd_ni` is high.
- R7: If `ack_i` is 1 at a rising clock edge while `int_o` is 0, the vector becomes {base, 3'b111} and no in-service bit changes.
- R8: A write with `addr_i`=0 and data bit 5 set is an end-of-interrupt command. It clears the lowest-numbered set in-service bit.
- R9: A write with `addr_i`=0 and data bit 4 set loads the vector base from data bits 7:3. The new base applies to vectors from later acknowledges.
- R10: While `rd_ni` is 0, `data_o` returns the pending register when `addr_i`=0 and the mask when `addr_i`=1. A write with `addr_i`=1 loads the mask from the data bus.
- R11: A write takes effect at each rising clock edge at which `wr_ni` is 0. Bus data presented while `wr_ni` is 1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 8 | Asynchronous interrupt request lines, bit 0 highest priority |
| wr_ni | input | 1 | Active-low write strobe, sampled each clock |
| rd_ni | input | 1 | Active-low read strobe |
| addr_i | input | 1 | Register select |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data when `rd_ni` is low, otherwise the last vector |
| ack_i | input | 1 | Interrupt acknowledge, sampled each clock |
| int_o | output | 1 | Interrupt request to the processor |

## Verification
On every cycle, the assertions check four things: an acknowledge taken while `int_o` is high adds exactly one in-service level, an end-of-interrupt removes exactly one, an acknowledge with no interrupt leaves the in-service set alone and returns line code 7, and `int_o` never rises without a pending, unmasked request that is not already in service. The nesting order itself needs the bench's scenarios to show it. That covers a lower-priority request held back behind a level in service, a higher-priority one breaking through, and the staged release as end-of-interrupt commands peel levels off. The same holds for the synchroniser latency, the held-level no-retrigger case and the base reload, which the cycle-by-cycle model tracks.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int unsigned NUM_IRQ = 8;
  localparam int unsigned IDX_W   = $clog2(NUM_IRQ);
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned BASE_W  = DATA_W - IDX_W;
  localparam int unsigned EOI_BIT = 5;
  localparam int unsigned BASE_BIT = 4;
endpackage

// File: rtl/nic_edge_sync.sv
module nic_edge_sync #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= irq_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise_o[g] = s2_q & ~s3_q;
  end
endmodule

// File: rtl/nic_prio_enc.sv
module nic_prio_enc #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic              wr_ni,
  input  logic              rd_ni,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  input  logic              ack_i,
  output logic              int_o
);
  logic [NUM_IRQ-1:0] rise_w, pend_w;
  logic [NUM_IRQ-1:0] irr_q, irr_d, isr_q, isr_d;
  logic [DATA_W-1:0]  mask_q, vec_q, vec_d;
  logic [BASE_W-1:0]  base_q;
  logic               pend_v, serv_v;
  logic [IDX_W-1:0]   pend_idx, serv_idx;
  logic               wr_en, ack_hit, eoi_cmd, base_ld, mask_ld;

  nic_edge_sync #(.N(NUM_IRQ)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .irq_i (irq_i),
    .rise_o(rise_w)
  );

  assign pend_w = irr_q & ~mask_q[NUM_IRQ-1:0];

  nic_prio_enc #(.N(NUM_IRQ)) u_pend (
    .req_i  (pend_w),
    .valid_o(pend_v),
    .idx_o  (pend_idx)
  );

  nic_prio_enc #(.N(NUM_IRQ)) u_serv (
    .req_i  (isr_q),
    .valid_o(serv_v),
    .idx_o  (serv_idx)
  );

  assign int_o   = pend_v && (!serv_v || (pend_idx < serv_idx));
  assign wr_en   = !wr_ni;
  assign ack_hit = ack_i && int_o;
  assign eoi_cmd = wr_en && !addr_i && data_i[EOI_BIT];
  assign base_ld = wr_en && !addr_i && data_i[BASE_BIT];
  assign mask_ld = wr_en && addr_i;

  always_comb begin
    isr_d = isr_q;
    irr_d = irr_q;
    vec_d = vec_q;
    if (eoi_cmd && serv_v) isr_d[serv_idx] = 1'b0;
    if (ack_i) begin
      if (ack_hit) begin
        isr_d[pend_idx] = 1'b1;
        irr_d[pend_idx] = 1'b0;
        vec_d = {base_q, pend_idx};
      end else begin
        vec_d = {base_q, {IDX_W{1'b1}}};
      end
    end
    // a fresh edge wins over a clear in the same cycle
    irr_d = irr_d | rise_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      isr_q  <= '0;
      mask_q <= '1;
      base_q <= '0;
      vec_q  <= '0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      vec_q <= vec_d;
      if (mask_ld) mask_q <= data_i;
      if (base_ld) base_q <= data_i[DATA_W-1:IDX_W];
    end
  end

  assign data_o = !rd_ni ? (addr_i ? mask_q : DATA_W'(irr_q)) : vec_q;

  AST_ACK_ADDS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_o && wr_ni) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1)); // R6

  AST_EOI_DROPS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_cmd && !(ack_i && int_o) && (isr_q != '0)) |=>
      ($countones(isr_q) + 1 == $past($countones(isr_q)))); // R8

  AST_SPURIOUS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !int_o && wr_ni) |=> ($stable(isr_q) && (vec_q[IDX_W-1:0] == {IDX_W{1'b1}}))); // R7

  AST_INT_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((pend_w != '0) && !isr_q[pend_idx])); // R4

  AST_NO_SAME_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_o && serv_v) |-> ((pend_w & isr_q) == '0 || pend_idx != serv_idx)); // R5
endmodule

// File: tb/tb_nest_irq_ctrl.sv
module tb_nest_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic [7:0] irq = '0;
  logic       wr_n = 1'b1, rd_n = 1'b1, addr = 1'b0, ack = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       intr;

  int n_chk = 0, n_fail = 0;

  nest_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .wr_ni(wr_n), .rd_ni(rd_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .ack_i(ack), .int_o(intr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit [7:0] m_irr, m_isr, m_mask, m_vec, m_s1, m_s2, m_s3, m_rise;
  bit [4:0] m_base;
  int       m_b, m_t;

  function automatic int lowest(bit [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit model_int();
    int b, t;
    b = lowest(m_irr & ~m_mask);
    t = lowest(m_isr);
    return (b < 8) && (b < t);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_irr = '0; m_isr = '0; m_mask = 8'hFF; m_vec = '0; m_base = '0;
      m_s1 = '0; m_s2 = '0; m_s3 = '0;
    end else begin
      m_b = lowest(m_irr & ~m_mask);
      m_t = lowest(m_isr);
      m_rise = m_s2 & ~m_s3;
      if (!wr_n && !addr && din[5] && m_t < 8) m_isr[m_t] = 1'b0;
      if (ack) begin
        if (m_b < 8 && m_b < m_t) begin
          m_isr[m_b] = 1'b1;
          m_irr[m_b] = 1'b0;
          m_vec = {m_base, 3'(m_b)};
        end else begin
          m_vec = {m_base, 3'b111};
        end
      end
      if (!wr_n) begin
        if (addr) m_mask = din;
        else if (din[4]) m_base = din[7:3];
      end
      m_irr = m_irr | m_rise;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = irq;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_ni) begin
      chk("R4 int_o vs model", {7'd0, intr}, {7'd0, model_int()});
      chk("R10 data_o vs model", dout,
          !rd_n ? (addr ? m_mask : m_irr) : m_vec);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit a, bit [7:0] d);
    @(negedge clk); wr_n = 1'b0; addr = a; din = d;
    @(negedge clk); wr_n = 1'b1; din = '0; addr = 1'b0;
  endtask

  task automatic rd(bit a, bit [7:0] exp, string tag);
    @(negedge clk); rd_n = 1'b0; addr = a;
    #2 chk(tag, dout, exp);
    @(negedge clk); rd_n = 1'b1; addr = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    tick(3);
    rst_ni = 1'b1;
    #2;
    chk("R1 int_o after reset", {7'd0, intr}, 8'd0);
    chk("R1 vector after reset", dout, 8'h00);
    rd(1'b1, 8'hFF, "R1 mask after reset");
    rd(1'b0, 8'h00, "R1 pending after reset");

    wr(1'b1, 8'h00);
    rd(1'b1, 8'h00, "R10 mask readback");
    wr(1'b0, 8'h50);                      // base 5'b01010

    @(negedge clk); irq[3] = 1'b1;
    tick(4); #2;
    chk("R2 int_o after edge on line 3", {7'd0, intr}, 8'd1);
    rd(1'b0, 8'h08, "R2 pending line 3");

    do_ack();
    chk("R6 vector line 3", dout, 8'h53);
    chk("R6 int_o drops after ack", {7'd0, intr}, 8'd0);
    tick(6);
    rd(1'b0, 8'h00, "R2 held level does not retrigger");

    @(negedge clk); irq[5] = 1'b1;
    tick(4); #2;
    chk("R5 lower level blocked", {7'd0, intr}, 8'd0);
    rd(1'b0, 8'h20, "R5 line 5 pending");
    @(negedge clk); irq[1] = 1'b1;
    tick(4); #2;
    chk("R5 higher level breaks through", {7'd0, intr}, 8'd1);
    do_ack();
    chk("R6 vector line 1", dout, 8'h51);
    chk("R5 nested blocks line 5", {7'd0, intr}, 8'd0);

    wr(1'b0, 8'h20); #2;
    chk("R8 first eoi keeps line 5 blocked", {7'd0, intr}, 8'd0);
    wr(1'b0, 8'h20); #2;
    chk("R8 second eoi releases line 5", {7'd0, intr}, 8'd1);

    wr(1'b1, 8'hFF); #2;
    chk("R3 masked line gives no int", {7'd0, intr}, 8'd0);
    rd(1'b0, 8'h20, "R3 masked request stays latched");
    do_ack();
    chk("R7 spurious vector", dout, 8'h57);
    wr(1'b1, 8'h00); #2;
    chk("R7 spurious ack left state", {7'd0, intr}, 8'd1);
    do_ack();
    chk("R6 vector line 5", dout, 8'h55);
    wr(1'b0, 8'h20);

    // R11: bus data without strobe is ignored
    @(negedge clk); addr = 1'b1; din = 8'hAA;
    tick(3); addr = 1'b0; din = '0;
    rd(1'b1, 8'h00, "R11 data without write strobe ignored");

    @(negedge clk); irq = '0;
    tick(4);
    wr(1'b0, 8'h18);                      // base 5'b00011
    @(negedge clk); irq[0] = 1'b1;
    tick(4); #2;
    chk("R4 line 0 raises int", {7'd0, intr}, 8'd1);
    do_ack();
    chk("R9 new base in vector", dout, 8'h18);
    wr(1'b0, 8'h20);
    tick(4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule